// File: doc/BRIEF.md
# Sectionable Management Port Address Decoder

This block decides which of eight port register banks in a multi-port transceiver a management-bus transaction addresses. A 5-bit base address comes from strap pins, and port n answers at base plus n. A section strap chooses between two arrangements. In unified mode, one access port reaches all eight ports. In split mode, there are two independent access ports of four ports each. Each access port supplies a PHY address from its frame engine. For each access port, the decoder returns a one-hot port select and a hit flag.

Both straps are sampled once, on the first clock after reset is released, and they stay fixed until the next reset. The decode itself is combinational from the access port addresses. This lets a frame engine compare the address field in the cycle it arrives.

Top module: `mdio_port_decoder`

## Requirements
- R1: Base and section straps are captured on the first rising clock edge after rst_ni goes high and are held until the next reset; later changes on the strap pins have no effect on any output.
- R2: While in reset, and until the capture edge, every select bit and both hit flags are 0.
- R3: In unified mode (section strap captured low), an address on access port 0 equal to (BASE + n) mod 32, with n in 0..7, sets bit n of sel0_o and raises hit0_o.
- R4: An address whose offset (address − BASE) mod 32 is 8 or more gives an all-zero select and no hit on that access port.
- R5: In unified mode, access port 1 never hits and sel1_o stays all-zero.
- R6: In split mode (section strap captured high), access port 0 answers only ports 0..3; the addresses of ports 4..7 give no select and no hit there.
- R7: In split mode, access port 1 answers only ports 4..7, setting bit n of sel1_o for port n; the addresses of ports 0..3 give no hit there.
- R8: The two access ports decode independently: each port's outputs depend only on its own address input.
- R9: Each select vector is one-hot or zero, and its hit flag is high exactly when a select bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_strap_i | input | 5 | Base PHY address strap |
| section_strap_i | input | 1 | High selects split (two-section) mode |
| addr0_i | input | 5 | PHY address from access port 0 |
| addr1_i | input | 5 | PHY address from access port 1 |
| sel0_o | output | 8 | One-hot port select for access port 0 |
| hit0_o | output | 1 | Address hit on access port 0 |
| sel1_o | output | 8 | One-hot port select for access port 1 |
| hit1_o | output | 1 | Address hit on access port 1 |

## Verification
The hardest case to reach is the window between the release of reset and the capture edge, and just after it. A decode done then must use neither stale nor later strap values. The bench releases reset on a falling edge and checks outputs before the capture edge. Right after the capture edge it drives new random values onto the straps, and it keeps them changing while the decode checks run. Bases near 31 are also forced, so that the modulo-32 wrap of port addresses is covered in both modes.

// File: rtl/mdio_dec_pkg.sv
package mdio_dec_pkg;
  localparam int unsigned NUM_PORTS_D = 8;
  localparam int unsigned ADDR_W_D    = 5;
  localparam int unsigned NUM_SEC_D   = 2;

  typedef struct packed {
    logic       done;
    logic       split;
    logic [ADDR_W_D-1:0] base;
  } strap_t;
endpackage

// File: rtl/mdio_strap_capture.sv
module mdio_strap_capture
  import mdio_dec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W_D-1:0] base_strap_i,
  input  logic                section_strap_i,
  output strap_t              strap_o
);
  strap_t strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
    end else if (!strap_q.done) begin
      strap_q.done  <= 1'b1;
      strap_q.split <= section_strap_i;
      strap_q.base  <= base_strap_i;
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/mdio_port_match.sv
module mdio_port_match #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_PORTS = 8,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic                 en_i,
  input  logic [PORT_W-1:0]    lo_i,
  input  logic [PORT_W-1:0]    hi_i,
  output logic [NUM_PORTS-1:0] sel_o,
  output logic                 hit_o
);
  localparam logic [ADDR_W-1:0] NP = ADDR_W'(NUM_PORTS);

  logic [ADDR_W-1:0] offset;
  logic [PORT_W-1:0] idx;
  logic              in_rng;

  // offset wraps modulo 2**ADDR_W
  assign offset = addr_i - base_i;
  assign idx    = offset[PORT_W-1:0];
  assign in_rng = en_i && (offset < NP) && (idx >= lo_i) && (idx <= hi_i);

  assign sel_o = in_rng ? (NUM_PORTS'(1) << idx) : '0;
  assign hit_o = in_rng;
endmodule

// File: rtl/mdio_port_decoder.sv
module mdio_port_decoder
  import mdio_dec_pkg::*;
#(
  parameter int unsigned NUM_PORTS = NUM_PORTS_D,
  parameter int unsigned ADDR_W    = ADDR_W_D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    base_strap_i,
  input  logic                 section_strap_i,
  input  logic [ADDR_W-1:0]    addr0_i,
  input  logic [ADDR_W-1:0]    addr1_i,
  output logic [NUM_PORTS-1:0] sel0_o,
  output logic                 hit0_o,
  output logic [NUM_PORTS-1:0] sel1_o,
  output logic                 hit1_o
);
  localparam int unsigned NUM_SEC   = NUM_SEC_D;
  localparam int unsigned SEC_PORTS = NUM_PORTS / NUM_SEC;
  localparam int unsigned PORT_W    = $clog2(NUM_PORTS);

  strap_t            strap;
  logic              cap_done;
  logic              split_q;
  logic [ADDR_W-1:0] base_q;

  logic [ADDR_W-1:0]    addr_a [NUM_SEC];
  logic [NUM_PORTS-1:0] sel_a  [NUM_SEC];
  logic                 hit_a  [NUM_SEC];

  mdio_strap_capture u_strap (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .base_strap_i    (base_strap_i),
    .section_strap_i (section_strap_i),
    .strap_o         (strap)
  );

  assign cap_done = strap.done;
  assign split_q  = strap.split;
  assign base_q   = strap.base;

  assign addr_a[0] = addr0_i;
  assign addr_a[1] = addr1_i;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic [PORT_W-1:0] lo, hi;
    logic              en;
    // unified mode: section 0 owns all ports, others are dark
    assign lo = split_q ? PORT_W'(s * SEC_PORTS)           : '0;
    assign hi = split_q ? PORT_W'((s + 1) * SEC_PORTS - 1) : PORT_W'(NUM_PORTS - 1);
    assign en = cap_done && (split_q || (s == 0));

    mdio_port_match #(
      .ADDR_W    (ADDR_W),
      .NUM_PORTS (NUM_PORTS)
    ) u_match (
      .addr_i (addr_a[s]),
      .base_i (base_q),
      .en_i   (en),
      .lo_i   (lo),
      .hi_i   (hi),
      .sel_o  (sel_a[s]),
      .hit_o  (hit_a[s])
    );
  end

  assign sel0_o = sel_a[0];
  assign hit0_o = hit_a[0];
  assign sel1_o = sel_a[1];
  assign hit1_o = hit_a[1];
endmodule

// File: rtl/mdio_port_decoder_chk.sv
module mdio_port_decoder_chk #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ADDR_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cap_done_i,
  input logic                 split_i,
  input logic [ADDR_W-1:0]    base_i,
  input logic [NUM_PORTS-1:0] sel0_i,
  input logic                 hit0_i,
  input logic [NUM_PORTS-1:0] sel1_i,
  input logic                 hit1_i
);
  localparam int unsigned HALF = NUM_PORTS / 2;

  p_strap_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_done_i && $past(cap_done_i)) |-> ($stable(split_i) && $stable(base_i)));

  p_quiet_before_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_done_i |-> (!hit0_i && !hit1_i && sel0_i == '0 && sel1_i == '0));

  p_sec1_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !split_i |-> (!hit1_i && sel1_i == '0));

  p_sec0_low_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_i |-> (sel0_i[NUM_PORTS-1:HALF] == '0));

  p_sec1_high_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel1_i[HALF-1:0] == '0);

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel0_i) && $onehot0(sel1_i) &&
    (hit0_i == (sel0_i != '0)) && (hit1_i == (sel1_i != '0)));
endmodule

bind mdio_port_decoder mdio_port_decoder_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_done_i (cap_done),
  .split_i    (split_q),
  .base_i     (base_q),
  .sel0_i     (sel0_o),
  .hit0_i     (hit0_o),
  .sel1_i     (sel1_o),
  .hit1_i     (hit1_o)
);

// File: tb/mdio_port_decoder_test.sv
module mdio_port_decoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] base_strap_i = '0;
  logic       section_strap_i = 1'b0;
  logic [4:0] addr0_i = '0, addr1_i = '0;
  logic [7:0] sel0_o, sel1_o;
  logic       hit0_o, hit1_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mdio_port_decoder uut (.*);

  // expected {hit, sel} for access port s
  function automatic logic [8:0] model(logic [4:0] a, logic [4:0] b, logic sp, int s);
    logic [4:0] off = a - b;
    if (off >= 5'd8) return '0;
    if (!sp) return (s == 0) ? {1'b1, 8'(1) << off} : '0;
    if (s == 0 && off < 5'd4) return {1'b1, 8'(1) << off};
    if (s == 1 && off >= 5'd4) return {1'b1, 8'(1) << off};
    return '0;
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive both addresses, check both access ports against the model
  task automatic probe(string req, logic [4:0] a0, logic [4:0] a1, logic [4:0] b, logic sp);
    @(negedge clk_i);
    addr0_i = a0; addr1_i = a1;
    #2;
    chk(req, {hit0_o, sel0_o}, model(a0, b, sp, 0));
    chk(req, {hit1_o, sel1_o}, model(a1, b, sp, 1));
  endtask

  // reset with given straps, check quiet window, then scramble strap pins
  task automatic boot(logic [4:0] b, logic sp);
    rst_ni = 1'b0;
    base_strap_i = b; section_strap_i = sp;
    addr0_i = b; addr1_i = b + 5'd4;
    repeat (2) @(negedge clk_i);
    chk("R2 in reset", {hit0_o, sel0_o, hit1_o, sel1_o} == '0 ? 9'd0 : 9'd1, 9'd0);
    rst_ni = 1'b1;
    #2;
    chk("R2 before capture", {hit0_o, sel0_o, hit1_o, sel1_o} == '0 ? 9'd0 : 9'd1, 9'd0);
    @(posedge clk_i);
    #1;
    base_strap_i = 5'($urandom);
    section_strap_i = ~sp;
  endtask

  initial begin
    void'($urandom(32'd1785));
    // R3 unified, base 4: ports answer at 4..11
    boot(5'd4, 1'b0);
    for (int n = 0; n < 8; n++) probe("R3 unified port", 5'(4 + n), 5'(4 + n), 5'd4, 1'b0);
    probe("R4 below base", 5'd3, 5'd3, 5'd4, 1'b0);
    probe("R4 above range", 5'd12, 5'd12, 5'd4, 1'b0);
    // R1 strap pins changed after capture: decode keeps base 4, unified
    section_strap_i = 1'b1; base_strap_i = 5'd0;
    probe("R1 strap change ignored", 5'd8, 5'd8, 5'd4, 1'b0);
    probe("R5 sec1 dark", 5'd6, 5'd10, 5'd4, 1'b0);

    // wrap across 31
    boot(5'd30, 1'b0);
    for (int n = 0; n < 8; n++) probe("R3 wrap", 5'(30 + n), 5'(30 + n), 5'd30, 1'b0);
    probe("R4 wrap miss", 5'd6, 5'd29, 5'd30, 1'b0);

    // split mode, base 8
    boot(5'd8, 1'b1);
    for (int n = 0; n < 8; n++) probe("R6 R7 split port", 5'(8 + n), 5'(8 + n), 5'd8, 1'b1);
    probe("R8 independent", 5'd9, 5'd14, 5'd8, 1'b1);
    probe("R8 independent swap", 5'd14, 5'd9, 5'd8, 1'b1);
    section_strap_i = 1'b0;
    probe("R1 split held", 5'd13, 5'd13, 5'd8, 1'b1);

    // split with wrap
    boot(5'd29, 1'b1);
    for (int n = 0; n < 8; n++) probe("R7 split wrap", 5'(29 + n), 5'(29 + n), 5'd29, 1'b1);

    // random bases and addresses
    for (int r = 0; r < 12; r++) begin
      logic [4:0] b = 5'($urandom);
      logic sp = 1'($urandom);
      boot(b, sp);
      for (int k = 0; k < 40; k++) begin
        base_strap_i = 5'($urandom);
        section_strap_i = 1'($urandom);
        probe("R9 random", 5'(b + ($urandom % 10)), 5'($urandom), b, sp);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule